// File: doc/BRIEF.md
# AC97 Dual-Phase Serial Frame Engine

This block is the link master for an AC97-style audio codec. It runs entirely on the bit clock taken from the codec clock input at divide-by-one. It builds the frame sync internally for both directions. Each frame carries one short command slot followed by a run of longer data slots. Transmit slot words leave on one serial line and receive slot words arrive on another, and both directions use the same slot layout.

On the system side, transmit words are requested one slot ahead through a ready/valid handshake. Each request is tagged with the index of the slot it will fill. Received slots come out as right-justified words with a slot index and a single-cycle valid strobe. At start-up the block holds the codec reset pin low for a set number of clocks. It then releases the pin and waits a further set number of clocks before the first frame begins.

Top module: `ac97_frame_engine`

## Requirements
- R1: After `rst_n` is released, `codec_rst_n` stays low for exactly `RST_LOW_CYC` clocks and then goes high. The first frame sync appears `CLK_WAIT_CYC` clocks after that. Before the first frame, `fsync`, `sd_out` and `tx_ready` are all low.
- R2: `fsync` is active high and rises every `FRAME_LEN` clocks. Each time it rises it stays high for `SYNC_W` clocks.
- R3: A frame carries slot 0 of `PH1_W` bits, then slots 1 to `PH2_SLOTS` of `PH2_W` bits each. The slots follow each other with no gaps and are sent most significant bit first. The first bit of slot 0 is on the line `DATA_DLY` clocks after `fsync` rises.
- R4: For a transmit slot of width w, only `tx_data[w-1:0]` is sent. All higher bits of the word are ignored.
- R5: `tx_ready` is high only while the one-word holding buffer is empty and the link is running. `tx_slot` gives the index of the slot that the next accepted word will fill. A word accepted on or before the clock edge at which its slot begins is sent in that slot.
- R6: A slot that begins with no word held or offered is sent as all zeros. It also sets `tx_underrun`, which stays high until reset.
- R7: `sd_in` is sampled on the falling clock edge, using the same layout as transmit. One clock after a slot's last bit, `rx_valid` pulses for one cycle. At the same time `rx_data` holds the slot bits right-justified and zero-extended, and `rx_slot` holds the slot index.
- R8: When the layout uses fewer than `FRAME_LEN` bits, the leftover bit times drive `sd_out` low. Those bit times produce no receive strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, taken from the codec clock input |
| rst_n | input | 1 | Asynchronous active-low block reset |
| codec_rst_n | output | 1 | Active-low reset pin to the codec |
| fsync | output | 1 | Frame sync, active high |
| sd_out | output | 1 | Serial transmit data |
| sd_in | input | 1 | Serial receive data |
| tx_data | input | WORD_W | Transmit slot word, right-justified |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding buffer can take a word |
| tx_slot | output | IDX_W | Slot index the next accepted word fills |
| tx_underrun | output | 1 | Sticky flag: a slot was sent empty |
| rx_data | output | WORD_W | Received slot bits, right-justified |
| rx_valid | output | 1 | One-cycle strobe for a received slot |
| rx_slot | output | IDX_W | Index of the received slot |

## Verification
The bench runs a configuration whose frame leaves padding bits, so the unused tail of each frame is exercised. It drives three input patterns. The first offers a word every cycle with the receive line looped back from transmit. This pins down bit order, slot boundaries, tag alignment and the exact cycles in which `tx_ready` is high. The second holds the offer off across several slot starts, which separates zero-filled underrun slots from late but valid words and shows that the flag stays set. The third offers words only every third cycle and drives an independent pseudo-random receive line, so that a receive path which merely echoed transmit data would be caught.

// File: rtl/ac97_fe_pkg.sv
`timescale 1ns/1ps
package ac97_fe_pkg;

   typedef enum logic [1:0] {
      RS_HOLD,
      RS_WAIT,
      RS_RUN
   } rs_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // bits needed to hold values 0..v
   function automatic int bits_for(input int v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/ac97_fe_rstseq.sv
`timescale 1ns/1ps
module ac97_fe_rstseq
   import ac97_fe_pkg::*;
#(
   parameter int RST_LOW_CYC  = 13,
   parameter int CLK_WAIT_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic codec_rst_n,
   output logic run
);

   localparam int CW = bits_for(imax(RST_LOW_CYC, CLK_WAIT_CYC));

   initial begin
      assert (RST_LOW_CYC >= 1)  else $fatal(1, "RST_LOW_CYC must be at least 1");
      assert (CLK_WAIT_CYC >= 1) else $fatal(1, "CLK_WAIT_CYC must be at least 1");
   end

   rs_state_e       st;
   logic [CW-1:0]   cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= RS_HOLD;
         cnt <= '0;
      end else begin
         case (st)
            RS_HOLD: begin
               if (cnt == CW'(RST_LOW_CYC - 1)) begin
                  st  <= RS_WAIT;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RS_WAIT: begin
               if (cnt == CW'(CLK_WAIT_CYC - 1)) begin
                  st  <= RS_RUN;
                  cnt <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: cnt <= cnt;
         endcase
      end
   end

   assign codec_rst_n = (st != RS_HOLD);
   assign run         = (st == RS_RUN);

endmodule

// File: rtl/ac97_fe_timer.sv
`timescale 1ns/1ps
module ac97_fe_timer
   import ac97_fe_pkg::*;
#(
   parameter int PH1_W     = 16,
   parameter int PH2_W     = 20,
   parameter int PH2_SLOTS = 12,
   parameter int FRAME_LEN = 256,
   parameter int SYNC_W    = 16,
   parameter int DATA_DLY  = 1,
   parameter int IDX_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic             fsync,
   output logic             in_data,
   output logic [IDX_W-1:0] slot,
   output logic             last_bit,
   output logic             slot_load,
   output logic [IDX_W-1:0] slot_load_idx
);

   localparam int NSLOT = 1 + PH2_SLOTS;
   localparam int SH_W  = imax(PH1_W, PH2_W);
   localparam int CNT_W = bits_for(FRAME_LEN - 1);
   localparam int BL_W  = bits_for(SH_W - 1);

   logic [CNT_W-1:0] bcnt, bcnt_nx;
   logic [BL_W-1:0]  bleft;
   logic             start, last_slot;

   always_comb begin
      bcnt_nx   = (bcnt == CNT_W'(FRAME_LEN - 1)) ? '0 : bcnt + 1'b1;
      start     = run && (bcnt_nx == CNT_W'(DATA_DLY));
      last_bit  = in_data && (bleft == '0);
      last_slot = (slot == IDX_W'(NSLOT - 1));
      slot_load = start || (run && last_bit && !last_slot);
      slot_load_idx = start ? '0 : slot + 1'b1;
      fsync     = run && (bcnt < CNT_W'(SYNC_W));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt    <= '0;
         bleft   <= '0;
         slot    <= '0;
         in_data <= 1'b0;
      end else if (run) begin
         bcnt <= bcnt_nx;
         if (start) begin
            in_data <= 1'b1;
            slot    <= '0;
            bleft   <= BL_W'(PH1_W - 1);
         end else if (in_data) begin
            if (bleft == '0) begin
               if (last_slot) begin
                  in_data <= 1'b0;
               end else begin
                  slot  <= slot + 1'b1;
                  bleft <= BL_W'(PH2_W - 1);
               end
            end else begin
               bleft <= bleft - 1'b1;
            end
         end
      end
   end

   a_r2_sync_period: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && $rose(fsync)) |-> ($past(bcnt) == CNT_W'(FRAME_LEN - 1)))
      else $error("sync rose off the frame boundary");

   a_r3_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
      in_data |-> (slot <= IDX_W'(NSLOT - 1)))
      else $error("slot index past the layout");

endmodule

// File: rtl/ac97_fe_tx.sv
`timescale 1ns/1ps
module ac97_fe_tx
   import ac97_fe_pkg::*;
#(
   parameter int PH1_W     = 16,
   parameter int PH2_W     = 20,
   parameter int PH2_SLOTS = 12,
   parameter int WORD_W    = 32,
   parameter int IDX_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              in_data,
   input  logic              slot_load,
   input  logic [IDX_W-1:0]  slot_load_idx,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [IDX_W-1:0]  tx_slot,
   output logic              tx_underrun,
   output logic              sd_out
);

   localparam int NSLOT = 1 + PH2_SLOTS;
   localparam int SH_W  = imax(PH1_W, PH2_W);

   logic [WORD_W-1:0] hold_q, ld_word;
   logic              full_q;
   logic [IDX_W-1:0]  req_idx;
   logic [SH_W-1:0]   sh, sh_ld;
   logic              take;
   logic              unused_ld;

   always_comb begin
      take     = tx_valid && tx_ready;
      ld_word  = full_q ? hold_q : (tx_valid ? tx_data : '0);
      if (slot_load_idx == '0) sh_ld = SH_W'(ld_word[PH1_W-1:0]) << (SH_W - PH1_W);
      else                     sh_ld = SH_W'(ld_word[PH2_W-1:0]) << (SH_W - PH2_W);
   end
   assign unused_ld = ^ld_word;

   assign tx_ready = run && !full_q;
   assign tx_slot  = req_idx;
   assign sd_out   = in_data & sh[SH_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q      <= '0;
         full_q      <= 1'b0;
         req_idx     <= '0;
         sh          <= '0;
         tx_underrun <= 1'b0;
      end else begin
         if (slot_load) begin
            sh      <= sh_ld;
            full_q  <= 1'b0;
            req_idx <= (slot_load_idx == IDX_W'(NSLOT - 1)) ? '0 : slot_load_idx + 1'b1;
            if (!full_q && !tx_valid) tx_underrun <= 1'b1;
         end else begin
            if (in_data) sh <= sh << 1;
            if (take) begin
               hold_q <= tx_data;
               full_q <= 1'b1;
            end
         end
      end
   end

   a_r5_full_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !slot_load) |=> !tx_ready)
      else $error("ready stayed high with a word held");

   a_r5_tag_align: assert property (@(posedge clk) disable iff (!rst_n)
      slot_load |-> (slot_load_idx == req_idx))
      else $error("requested tag differs from the slot being loaded");

   a_r6_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underrun |=> tx_underrun)
      else $error("underrun flag cleared without reset");

endmodule

// File: rtl/ac97_fe_rx.sv
`timescale 1ns/1ps
module ac97_fe_rx
   import ac97_fe_pkg::*;
#(
   parameter int PH1_W   = 16,
   parameter int PH2_W   = 20,
   parameter int WORD_W  = 32,
   parameter int IDX_W   = 4,
   parameter bit RX_FALL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sd_in,
   input  logic              in_data,
   input  logic              last_bit,
   input  logic [IDX_W-1:0]  slot,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_valid,
   output logic [IDX_W-1:0]  rx_slot
);

   localparam int SH_W = imax(PH1_W, PH2_W);

   logic              bit_now;
   logic [SH_W-2:0]   acc;
   logic [SH_W-1:0]   word;

   generate
      if (RX_FALL) begin : g_fall
         logic smp;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) smp <= 1'b0;
            else        smp <= sd_in;
         end
         assign bit_now = smp;
      end else begin : g_rise
         assign bit_now = sd_in;
      end
   endgenerate

   assign word = {acc, bit_now};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= '0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
         rx_slot  <= '0;
      end else begin
         rx_valid <= 1'b0;
         if (in_data) acc <= word[SH_W-2:0];
         if (last_bit) begin
            rx_valid <= 1'b1;
            rx_slot  <= slot;
            rx_data  <= (slot == '0) ? WORD_W'(word[PH1_W-1:0]) : WORD_W'(word[PH2_W-1:0]);
         end
      end
   end

   a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid)
      else $error("receive strobe held for more than one cycle");

endmodule

// File: rtl/ac97_frame_engine.sv
`timescale 1ns/1ps
module ac97_frame_engine
   import ac97_fe_pkg::*;
#(
   parameter int PH1_W        = 16,
   parameter int PH2_W        = 20,
   parameter int PH2_SLOTS    = 12,
   parameter int FRAME_LEN    = 256,
   parameter int SYNC_W       = 16,
   parameter int DATA_DLY     = 1,
   parameter int RST_LOW_CYC  = 13,
   parameter int CLK_WAIT_CYC = 8,
   parameter int WORD_W       = 32,
   parameter int IDX_W        = 4,
   parameter bit RX_FALL      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              codec_rst_n,
   output logic              fsync,
   output logic              sd_out,
   input  logic              sd_in,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [IDX_W-1:0]  tx_slot,
   output logic              tx_underrun,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_valid,
   output logic [IDX_W-1:0]  rx_slot
);

   localparam int NSLOT = 1 + PH2_SLOTS;
   localparam int USED  = PH1_W + PH2_SLOTS * PH2_W;

   initial begin
      assert (PH1_W >= 2 && PH2_W >= 2)   else $fatal(1, "slot widths must be at least 2");
      assert (imax(PH1_W, PH2_W) <= WORD_W) else $fatal(1, "slot wider than the word");
      assert (PH2_SLOTS >= 1)             else $fatal(1, "need at least one phase-2 slot");
      assert (NSLOT <= (1 << IDX_W))      else $fatal(1, "IDX_W too narrow");
      assert (USED <= FRAME_LEN)          else $fatal(1, "layout longer than the frame");
      assert (SYNC_W >= 1 && SYNC_W < FRAME_LEN) else $fatal(1, "bad sync width");
      assert (DATA_DLY >= 1 && DATA_DLY < FRAME_LEN) else $fatal(1, "bad data delay");
   end

   logic             run, in_data, last_bit, slot_load;
   logic [IDX_W-1:0] slot, slot_load_idx;

   ac97_fe_rstseq #(
      .RST_LOW_CYC (RST_LOW_CYC),
      .CLK_WAIT_CYC(CLK_WAIT_CYC)
   ) u_rstseq (
      .clk        (clk),
      .rst_n      (rst_n),
      .codec_rst_n(codec_rst_n),
      .run        (run)
   );

   ac97_fe_timer #(
      .PH1_W    (PH1_W),
      .PH2_W    (PH2_W),
      .PH2_SLOTS(PH2_SLOTS),
      .FRAME_LEN(FRAME_LEN),
      .SYNC_W   (SYNC_W),
      .DATA_DLY (DATA_DLY),
      .IDX_W    (IDX_W)
   ) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run),
      .fsync        (fsync),
      .in_data      (in_data),
      .slot         (slot),
      .last_bit     (last_bit),
      .slot_load    (slot_load),
      .slot_load_idx(slot_load_idx)
   );

   ac97_fe_tx #(
      .PH1_W    (PH1_W),
      .PH2_W    (PH2_W),
      .PH2_SLOTS(PH2_SLOTS),
      .WORD_W   (WORD_W),
      .IDX_W    (IDX_W)
   ) u_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .run          (run),
      .in_data      (in_data),
      .slot_load    (slot_load),
      .slot_load_idx(slot_load_idx),
      .tx_data      (tx_data),
      .tx_valid     (tx_valid),
      .tx_ready     (tx_ready),
      .tx_slot      (tx_slot),
      .tx_underrun  (tx_underrun),
      .sd_out       (sd_out)
   );

   ac97_fe_rx #(
      .PH1_W  (PH1_W),
      .PH2_W  (PH2_W),
      .WORD_W (WORD_W),
      .IDX_W  (IDX_W),
      .RX_FALL(RX_FALL)
   ) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .sd_in   (sd_in),
      .in_data (in_data),
      .last_bit(last_bit),
      .slot    (slot),
      .rx_data (rx_data),
      .rx_valid(rx_valid),
      .rx_slot (rx_slot)
   );

   a_r1_sync_after_release: assert property (@(posedge clk) disable iff (!rst_n)
      fsync |-> codec_rst_n)
      else $error("frame sync while codec held in reset");

   a_r8_no_strobe_in_pad: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_data && !$past(in_data)) |-> !rx_valid)
      else $error("receive strobe outside slot bits");

endmodule

// File: tb/ac97_frame_engine_tb.sv
`timescale 1ns/1ps
module ac97_frame_engine_tb;

   localparam int CLK_PERIOD = 8;
   localparam int L_RST  = 13;
   localparam int L_WAIT = 6;
   localparam int F      = 256;
   localparam int SYNC   = 16;
   localparam int DLY    = 1;
   localparam int P1     = 16;
   localparam int P2     = 20;
   localparam int NS2    = 11;
   localparam int USED   = P1 + NS2 * P2;
   localparam int START  = L_RST + L_WAIT;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        codec_rst_n, fsync, sd_out, tx_ready, tx_underrun, rx_valid;
   logic [31:0] tx_data = '0;
   logic        tx_valid = 1'b0;
   logic [3:0]  tx_slot, rx_slot;
   logic [31:0] rx_data;
   logic        loop_en = 1'b1;
   logic        rx_drive = 1'b0;
   logic        rx_line;

   assign rx_line = loop_en ? sd_out : rx_drive;

   always #(CLK_PERIOD/2) clk = ~clk;

   ac97_frame_engine #(
      .PH1_W(P1), .PH2_W(P2), .PH2_SLOTS(NS2), .FRAME_LEN(F), .SYNC_W(SYNC),
      .DATA_DLY(DLY), .RST_LOW_CYC(L_RST), .CLK_WAIT_CYC(L_WAIT),
      .WORD_W(32), .IDX_W(4), .RX_FALL(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .codec_rst_n(codec_rst_n), .fsync(fsync),
      .sd_out(sd_out), .sd_in(rx_line), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .tx_slot(tx_slot), .tx_underrun(tx_underrun),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_slot(rx_slot)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   int          q_tag [0:1023];
   logic [31:0] q_dat [0:1023];
   int          qh = 0, qt = 0;
   logic [31:0] acc_tx = '0, acc_rx = '0;
   bit          pend = 1'b0;
   logic [31:0] pend_val = '0;
   int          pend_slot = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int c, bc, f, p, s, b, w;
      logic [31:0] mask, exp_v;
      repeat (5) @(posedge clk);
      for (int n = 0; n < START + 7*F + 30; n++) begin
         @(posedge clk);
         #(CLK_PERIOD/4);
         if (n == 0) rst_n = 1'b1;
         c  = n - START;
         bc = (c >= 0) ? c % F : 0;
         f  = (c >= 0) ? c / F : -1;
         // stimulus
         if (c < 0)        tx_valid = 1'b0;
         else if (f < 3)   tx_valid = 1'b1;
         else if (f == 3)  tx_valid = !(bc >= 40 && bc < 120);
         else              tx_valid = (n % 3 == 0);
         loop_en  = (f < 4);
         tx_data  = 32'h9E3779B1 * (qt + 1);
         rx_drive = ^(n * 32'h6D2B79F5);
         #(CLK_PERIOD/2);
         // R1: codec reset pin and quiet link before the first frame
         check(codec_rst_n == (n >= L_RST), "R1 codec_rst_n", {31'b0, codec_rst_n}, {31'b0, n >= L_RST});
         if (c < 0) begin
            check(!fsync && !sd_out && !tx_ready, "R1 idle before start",
                  {29'b0, fsync, sd_out, tx_ready}, 32'h0);
            continue;
         end
         // R2: sync shape
         check(fsync == (bc < SYNC), "R2 fsync", {31'b0, fsync}, {31'b0, bc < SYNC});
         // R7 / R8: receive strobe expected only right after a slot's last bit
         if (pend) begin
            check(rx_valid && rx_data == pend_val && rx_slot == 4'(pend_slot), "R7 rx word",
                  rx_data, pend_val);
         end else begin
            check(!rx_valid, "R8 no stray rx strobe", {31'b0, rx_valid}, 32'h0);
         end
         pend = 1'b0;
         p = bc - DLY;
         if (p >= 0 && p < USED) begin
            if (p < P1) begin s = 0; w = P1; b = P1 - 1 - p; end
            else begin s = 1 + (p - P1) / P2; w = P2; b = P2 - 1 - (p - P1) % P2; end
            acc_tx = {acc_tx[30:0], sd_out};
            acc_rx = {acc_rx[30:0], rx_line};
            if (f == 1 || f == 2)
               check(tx_ready == (b == w - 1), "R5 ready only right after a slot load",
                     {31'b0, tx_ready}, {31'b0, b == w - 1});
            if (b == 0) begin
               mask = (32'h1 << w) - 32'h1;
               if (qh < qt && q_tag[qh] == s) begin
                  exp_v = q_dat[qh] & mask;
                  qh++;
               end else begin
                  exp_v = '0; // R6 zero-filled slot
               end
               check((acc_tx & mask) == exp_v, "R3 R4 R6 tx slot", acc_tx & mask, exp_v);
               pend      = 1'b1;
               pend_val  = acc_rx & mask;
               pend_slot = s;
            end
         end else begin
            check(!sd_out, "R8 pad bit low", {31'b0, sd_out}, 32'h0);
         end
         if (c == 3*F + 39)  check(!tx_underrun, "R6 no underrun yet", {31'b0, tx_underrun}, 32'h0);
         if (c == 3*F + 130) check(tx_underrun,  "R6 underrun set", {31'b0, tx_underrun}, 32'h1);
         if (c == 7*F + 20)  check(tx_underrun,  "R6 underrun sticky", {31'b0, tx_underrun}, 32'h1);
         // R5: record accepted word with its tag
         if (tx_valid && tx_ready) begin
            q_tag[qt] = int'(tx_slot);
            q_dat[qt] = tx_data;
            qt++;
         end
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule